// File: doc/BRIEF.md
# Disk Controller Interrupt Status Logic

This block owns the interrupt request line of a floppy-style disk controller and answers the sense-interrupt-status query. The command sequencer sends it event pulses. One pulse marks entry into the result phase of a data-transfer command. Another marks the finish of a seek-type command (seek, relative seek or recalibrate) and carries the drive number, a normal or abnormal flag and the cylinder the head now sits on. While any cause is pending, the block holds its interrupt output high.

Seek-type commands have no result phase of their own. They are closed only by a later sense-interrupt query. Until that query, the drive that completed stays flagged busy, so the sequencer can hold off new commands to it. Completions from up to four drives are queued. Each query reports and retires exactly one cause, and the lowest drive number goes first. A transfer-phase cause is reported only after all seek completions. The answer is two bytes on consecutive cycles: a status byte that encodes the cause, then the present cylinder number.

Top module: `fdc_irq_status`

## Requirements
- R1: After reset the interrupt output is low, every busy flag is clear and no result byte is valid.
- R2: A transfer result pulse raises the interrupt output from the next cycle on.
- R3: A seek completion pulse raises the interrupt output and sets the busy flag of its drive from the next cycle on.
- R4: An accepted sense pulse produces two valid result bytes on the next two cycles: first the status byte, then the cylinder byte, with the last-byte flag high only on the second.
- R5: A normal seek completion is reported as status 0x20 ORed with the drive number in bits 1:0 (cause field bits 7:6 = 00, seek-end bit 5 = 1), followed by the cylinder carried with that completion.
- R6: An abnormal seek completion is reported as status 0x60 ORed with the drive number (cause field = 01, seek-end bit = 1), followed by its cylinder.
- R7: A transfer cause is reported as status 0xC0 ORed with the drive given with the pulse (cause field = 11, seek-end bit = 0), followed by the last cylinder recorded for that drive, which is 0 after reset.
- R8: Bits 4 to 2 of every status byte read 0, which includes the head address bit 2.
- R9: With several causes pending, each sense reports and retires one of them: the lowest pending drive first, and the transfer cause only when no seek completion is left. The busy flag clears only for the drive that was reported.
- R10: The interrupt output stays high while any cause is pending. It drops in the cycle after the sense that retires the last one.
- R11: A sense with nothing pending returns status 0x80 (cause field = 10) and cylinder 0, and leaves the interrupt output and the busy flags unchanged.
- R12: A seek completion for a drive that arrives in the same cycle as the sense reporting that drive is kept pending, with the new cylinder and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_done_i | input | 1 | Result-phase entry pulse of a data-transfer command |
| xfer_drive_i | input | 2 | Drive of that transfer command |
| seek_done_i | input | 1 | Seek, relative seek or recalibrate finished |
| seek_drive_i | input | 2 | Drive of the finished seek-type command |
| seek_fail_i | input | 1 | Seek-type command ended abnormally |
| seek_cyl_i | input | CYL_W | Cylinder under the head after the seek |
| sense_i | input | 1 | Sense-interrupt-status command issued |
| irq_o | output | 1 | Interrupt request |
| drive_busy_o | output | NUM_DRIVES | Per-drive busy flag of an unacknowledged seek |
| res_valid_o | output | 1 | Result byte valid |
| res_last_o | output | 1 | Result byte is the second (cylinder) byte |
| res_byte_o | output | 8 | Result byte |

## Verification
The assertions assume that the sequencer issues no sense pulse while a result is still being returned, and that each drive number it gives is below NUM_DRIVES. Under those assumptions, every result is exactly two beats long and the fixed status bits can be checked on the first beat. The bench respects both rules. It waits out the full two-beat result and one idle cycle after each sense, and it draws drive numbers from 0 to 3 only. Random mixes of seeks, transfer pulses and queries are combined with directed cases: the empty query, the four-deep queue and a completion that collides with its own report.

// File: rtl/fdc_irq_pkg.sv
package fdc_irq_pkg;

   typedef enum logic [1:0] {
      IC_NORMAL   = 2'b00,
      IC_ABNORMAL = 2'b01,
      IC_INVALID  = 2'b10,
      IC_POLL     = 2'b11
   } ic_e;

   typedef struct packed {
      ic_e        ic;
      logic       seek_end;
      logic       equip_chk;
      logic       not_ready;
      logic       head;
      logic [1:0] drive;
   } st0_t;

   typedef enum logic [1:0] {
      BEAT_IDLE = 2'b00,
      BEAT_ST0  = 2'b01,
      BEAT_CYL  = 2'b10
   } beat_e;

   function automatic st0_t build_st0(ic_e ic, logic seek_end, logic [1:0] drive);
      st0_t s;
      s.ic        = ic;
      s.seek_end  = seek_end;
      s.equip_chk = 1'b0;
      s.not_ready = 1'b0;
      s.head      = 1'b0;
      s.drive     = drive;
      return s;
   endfunction

endpackage

// File: rtl/fdc_seek_slot.sv
module fdc_seek_slot #(
   parameter int CYL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             fail_i,
   input  logic [CYL_W-1:0] cyl_i,
   input  logic             clr_i,
   output logic             pend_o,
   output logic             fail_o,
   output logic [CYL_W-1:0] cyl_o
);

   logic             pend_q;
   logic             fail_q;
   logic [CYL_W-1:0] cyl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         fail_q <= 1'b0;
         cyl_q  <= '0;
      end else if (set_i) begin
         pend_q <= 1'b1;
         fail_q <= fail_i;
         cyl_q  <= cyl_i;
      end else if (clr_i) begin
         pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;
   assign fail_o = fail_q;
   assign cyl_o  = cyl_q;

endmodule

// File: rtl/fdc_prio_pick.sv
module fdc_prio_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/fdc_result_seq.sv
module fdc_result_seq
   import fdc_irq_pkg::*;
#(
   parameter int CYL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [7:0]       st0_i,
   input  logic [CYL_W-1:0] cyl_i,
   output logic             busy_o,
   output logic             valid_o,
   output logic             last_o,
   output logic [7:0]       byte_o
);

   beat_e      beat_q;
   logic [7:0] st0_q;
   logic [7:0] cyl_q;
   logic [7:0] cyl_ext;

   generate
      if (CYL_W == 8) begin : g_full
         assign cyl_ext = cyl_i;
      end else begin : g_pad
         assign cyl_ext = {{(8 - CYL_W){1'b0}}, cyl_i};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         beat_q <= BEAT_IDLE;
         st0_q  <= '0;
         cyl_q  <= '0;
      end else begin
         case (beat_q)
            BEAT_IDLE: if (start_i) begin
               beat_q <= BEAT_ST0;
               st0_q  <= st0_i;
               cyl_q  <= cyl_ext;
            end
            BEAT_ST0: beat_q <= BEAT_CYL;
            default:  beat_q <= BEAT_IDLE;
         endcase
      end
   end

   assign busy_o  = (beat_q != BEAT_IDLE);
   assign valid_o = (beat_q != BEAT_IDLE);
   assign last_o  = (beat_q == BEAT_CYL);
   assign byte_o  = (beat_q == BEAT_CYL) ? cyl_q : st0_q;

endmodule

// File: rtl/fdc_irq_status.sv
module fdc_irq_status
   import fdc_irq_pkg::*;
#(
   parameter int NUM_DRIVES = 4,
   parameter int CYL_W      = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  xfer_done_i,
   input  logic [1:0]            xfer_drive_i,
   input  logic                  seek_done_i,
   input  logic [1:0]            seek_drive_i,
   input  logic                  seek_fail_i,
   input  logic [CYL_W-1:0]      seek_cyl_i,
   input  logic                  sense_i,
   output logic                  irq_o,
   output logic [NUM_DRIVES-1:0] drive_busy_o,
   output logic                  res_valid_o,
   output logic                  res_last_o,
   output logic [7:0]            res_byte_o
);

   localparam int DRV_W = 2;
   localparam int SLOTS = 1 << DRV_W;

   generate
      if (NUM_DRIVES < 1 || NUM_DRIVES > SLOTS) begin : g_bad_drives
         $error("NUM_DRIVES must lie between 1 and 4");
      end
      if (CYL_W < 1 || CYL_W > 8) begin : g_bad_cyl
         $error("CYL_W must lie between 1 and 8");
      end
   endgenerate

   logic [NUM_DRIVES-1:0] pend;
   logic [NUM_DRIVES-1:0] fail;
   logic [NUM_DRIVES-1:0] clr;
   logic [NUM_DRIVES-1:0] set;
   logic [CYL_W-1:0]      cyl_all [SLOTS];

   logic             pick_found;
   logic [DRV_W-1:0] pick_idx;
   logic             seq_busy;
   logic             accept;
   logic             xpend_q;
   logic [DRV_W-1:0] xdrv_q;
   logic             xclr;
   st0_t             st0_sel;
   logic [CYL_W-1:0] cyl_sel;

   assign accept = sense_i && !seq_busy;

   genvar gi;
   generate
      for (gi = 0; gi < SLOTS; gi++) begin : g_slot
         if (gi < NUM_DRIVES) begin : g_live
            assign set[gi] = seek_done_i && (seek_drive_i == DRV_W'(gi));
            assign clr[gi] = accept && pick_found && (pick_idx == DRV_W'(gi));
            fdc_seek_slot #(.CYL_W(CYL_W)) u_slot (
               .clk    (clk),
               .rst_n  (rst_n),
               .set_i  (set[gi]),
               .fail_i (seek_fail_i),
               .cyl_i  (seek_cyl_i),
               .clr_i  (clr[gi]),
               .pend_o (pend[gi]),
               .fail_o (fail[gi]),
               .cyl_o  (cyl_all[gi])
            );
         end else begin : g_absent
            assign cyl_all[gi] = '0;
         end
      end
   endgenerate

   fdc_prio_pick #(.N(NUM_DRIVES), .IDX_W(DRV_W)) u_pick (
      .req_i   (pend),
      .found_o (pick_found),
      .idx_o   (pick_idx)
   );

   always_comb begin
      xclr = 1'b0;
      if (pick_found) begin
         st0_sel = build_st0(fail[pick_idx] ? IC_ABNORMAL : IC_NORMAL, 1'b1, pick_idx);
         cyl_sel = cyl_all[pick_idx];
      end else if (xpend_q) begin
         st0_sel = build_st0(IC_POLL, 1'b0, xdrv_q);
         cyl_sel = cyl_all[xdrv_q];
         xclr    = accept;
      end else begin
         st0_sel = build_st0(IC_INVALID, 1'b0, '0);
         cyl_sel = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xpend_q <= 1'b0;
         xdrv_q  <= '0;
      end else if (xfer_done_i) begin
         xpend_q <= 1'b1;
         xdrv_q  <= xfer_drive_i;
      end else if (xclr) begin
         xpend_q <= 1'b0;
      end
   end

   fdc_result_seq #(.CYL_W(CYL_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (accept),
      .st0_i   (st0_sel),
      .cyl_i   (cyl_sel),
      .busy_o  (seq_busy),
      .valid_o (res_valid_o),
      .last_o  (res_last_o),
      .byte_o  (res_byte_o)
   );

   assign irq_o        = (|pend) || xpend_q;
   assign drive_busy_o = pend;

endmodule

// File: rtl/fdc_irq_status_chk.sv
module fdc_irq_status_chk #(
   parameter int NUM_DRIVES = 4,
   parameter int CYL_W      = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  xfer_done_i,
   input logic                  seek_done_i,
   input logic [1:0]            seek_drive_i,
   input logic                  sense_i,
   input logic                  irq_o,
   input logic [NUM_DRIVES-1:0] drive_busy_o,
   input logic                  res_valid_o,
   input logic                  res_last_o,
   input logic [7:0]            res_byte_o
);

   p_busy_means_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|drive_busy_o) |-> irq_o);

   p_xfer_raises_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done_i |=> irq_o);

   p_seek_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seek_done_i |=> (irq_o && drive_busy_o[$past(seek_drive_i)]));

   p_sense_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i && !res_valid_o) |=> (res_valid_o && !res_last_o));

   p_second_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_last_o) |=> (res_valid_o && res_last_o));

   p_result_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (res_last_o && !sense_i) |=> !res_valid_o);

   p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_o && !res_last_o) |-> (res_byte_o[4:2] == 3'b000));

   p_busy_clear_by_sense_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(sense_i && !res_valid_o) |=> (($past(drive_busy_o) & ~drive_busy_o) == '0));

   p_empty_sense_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_i && !res_valid_o && !irq_o && !seek_done_i && !xfer_done_i)
         |=> (res_byte_o == 8'h80 && !irq_o && drive_busy_o == '0));

endmodule

bind fdc_irq_status fdc_irq_status_chk #(.NUM_DRIVES(NUM_DRIVES), .CYL_W(CYL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .xfer_done_i  (xfer_done_i),
   .seek_done_i  (seek_done_i),
   .seek_drive_i (seek_drive_i),
   .sense_i      (sense_i),
   .irq_o        (irq_o),
   .drive_busy_o (drive_busy_o),
   .res_valid_o  (res_valid_o),
   .res_last_o   (res_last_o),
   .res_byte_o   (res_byte_o)
);

// File: tb/fdc_irq_status_test.sv
`timescale 1ns/1ps
module fdc_irq_status_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       xfer_done = 1'b0;
   logic [1:0] xfer_drive = '0;
   logic       seek_done = 1'b0;
   logic [1:0] seek_drive = '0;
   logic       seek_fail = 1'b0;
   logic [7:0] seek_cyl = '0;
   logic       sense = 1'b0;
   logic       irq;
   logic [3:0] busy;
   logic       rvalid;
   logic       rlast;
   logic [7:0] rbyte;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   bit       m_pend [4];
   bit       m_fail [4];
   bit [7:0] m_cyl  [4];
   bit       m_xpend;
   bit [1:0] m_xdrv;

   always #10 clk = ~clk;

   fdc_irq_status uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .xfer_done_i  (xfer_done),
      .xfer_drive_i (xfer_drive),
      .seek_done_i  (seek_done),
      .seek_drive_i (seek_drive),
      .seek_fail_i  (seek_fail),
      .seek_cyl_i   (seek_cyl),
      .sense_i      (sense),
      .irq_o        (irq),
      .drive_busy_o (busy),
      .res_valid_o  (rvalid),
      .res_last_o   (rlast),
      .res_byte_o   (rbyte)
   );

   task automatic check(string req, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   function automatic bit [3:0] exp_busy();
      bit [3:0] b;
      for (int i = 0; i < 4; i++) b[i] = m_pend[i];
      return b;
   endfunction

   function automatic bit exp_irq();
      return (exp_busy() != 4'b0) || m_xpend;
   endfunction

   function automatic int lowest_pend();
      for (int i = 0; i < 4; i++) if (m_pend[i]) return i;
      return -1;
   endfunction

   task automatic check_state(string req);
      check(req, "irq", int'(irq), int'(exp_irq()));
      check(req, "busy", int'(busy), int'(exp_busy()));
   endtask

   task automatic do_seek(bit [1:0] d, bit f, bit [7:0] c);
      seek_done = 1'b1; seek_drive = d; seek_fail = f; seek_cyl = c;
      @(posedge clk); @(negedge clk);
      seek_done = 1'b0;
      m_pend[d] = 1'b1; m_fail[d] = f; m_cyl[d] = c;
      check_state("R3");
   endtask

   task automatic do_xfer(bit [1:0] d);
      xfer_done = 1'b1; xfer_drive = d;
      @(posedge clk); @(negedge clk);
      xfer_done = 1'b0;
      m_xpend = 1'b1; m_xdrv = d;
      check_state("R2");
   endtask

   // expected result of a query from the model, then the model is updated
   task automatic predict(output bit [7:0] st0, output bit [7:0] cyl);
      int d;
      d = lowest_pend();
      if (d >= 0) begin
         st0 = (m_fail[d] ? 8'h60 : 8'h20) | 8'(d);
         cyl = m_cyl[d];
         m_pend[d] = 1'b0;
      end else if (m_xpend) begin
         st0 = 8'hC0 | 8'(m_xdrv);
         cyl = m_cyl[m_xdrv];
         m_xpend = 1'b0;
      end else begin
         st0 = 8'h80;
         cyl = 8'h00;
      end
   endtask

   task automatic finish_sense(string req, bit [7:0] st0, bit [7:0] cyl);
      check("R4", "beat0 valid", int'(rvalid), 1);
      check("R4", "beat0 last", int'(rlast), 0);
      check(req, "status byte", int'(rbyte), int'(st0));
      check("R8", "status bits 4:2", int'(rbyte[4:2]), 0);
      @(posedge clk); @(negedge clk);
      check("R4", "beat1 valid", int'(rvalid), 1);
      check("R4", "beat1 last", int'(rlast), 1);
      check(req, "cylinder byte", int'(rbyte), int'(cyl));
      @(posedge clk); @(negedge clk);
      check("R4", "idle valid", int'(rvalid), 0);
      check_state("R10");
   endtask

   task automatic do_sense(string req);
      bit [7:0] st0, cyl;
      predict(st0, cyl);
      sense = 1'b1;
      @(posedge clk); @(negedge clk);
      sense = 1'b0;
      check_state("R9");
      finish_sense(req, st0, cyl);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 4; i++) begin
         m_pend[i] = 0; m_fail[i] = 0; m_cyl[i] = 0;
      end
      m_xpend = 0; m_xdrv = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1", "irq", int'(irq), 0);
      check("R1", "busy", int'(busy), 0);
      check("R1", "valid", int'(rvalid), 0);

      // R11 empty query changes nothing
      do_sense("R11");

      // R7 transfer cause before any seek: cylinder 0
      do_xfer(2'd2);
      check("R2", "irq after transfer", int'(irq), 1);
      do_sense("R7");
      check("R10", "irq dropped", int'(irq), 0);

      // R5 normal seek and R6 abnormal seek
      do_seek(2'd1, 1'b0, 8'd77);
      do_sense("R5");
      do_seek(2'd3, 1'b1, 8'd5);
      do_sense("R6");

      // R9 queue of four plus a transfer cause, reversed arrival order
      do_xfer(2'd1);
      do_seek(2'd3, 1'b0, 8'd30);
      do_seek(2'd2, 1'b1, 8'd20);
      do_seek(2'd1, 1'b0, 8'd10);
      do_seek(2'd0, 1'b1, 8'd200);
      check("R9", "all busy", int'(busy), 4'hF);
      for (int k = 0; k < 5; k++) do_sense("R9");
      check("R10", "irq low after drain", int'(irq), 0);
      check("R7", "transfer reported last cyl", int'(m_cyl[1]), 10);

      // R12 completion colliding with its own report
      do_seek(2'd2, 1'b0, 8'd40);
      begin
         bit [7:0] st0, cyl;
         predict(st0, cyl);
         sense = 1'b1;
         seek_done = 1'b1; seek_drive = 2'd2; seek_fail = 1'b1; seek_cyl = 8'd41;
         @(posedge clk); @(negedge clk);
         sense = 1'b0; seek_done = 1'b0;
         m_pend[2] = 1'b1; m_fail[2] = 1'b1; m_cyl[2] = 8'd41;
         check("R12", "busy kept", int'(busy[2]), 1);
         finish_sense("R12", st0, cyl);
         do_sense("R12");
      end

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         op = int'($urandom_range(0, 5));
         if (op <= 1) do_seek(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
         else if (op == 2) do_xfer(2'($urandom_range(0, 3)));
         else do_sense("R9");
      end
      while (exp_irq()) do_sense("R10");
      do_sense("R11");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule